// File: doc/BRIEF.md
# Half-Duplex Serial Flash Master

This block is a polled serial flash master behind a small 32-bit register bus. Software sets the byte ordering in a configuration register. It sets the chip-select levels, the transfer length and the engine's target line in a control word. Each accepted access to the data register then launches one serial transfer of one or four bytes. A write sends bytes on the serial output. A read starts a receive from the serial input into a capture word, and that word is returned by the next data-register read. Data moves in one direction only per transfer. Software polls a ready flag between transfers.

The serial clock is the system clock divided by a fixed parameter. Data moves MSB first in SPI mode 0. Two active-low chip selects can be held low by software across several transfers. The line chosen by the target-select field is also pulled low automatically while the engine shifts.

Top module: `spi_flash_master`

## Requirements
- R1: After reset both chip-select pins are high, the serial clock is low, the configuration register reads 0x00000000 and the control word reads 0xC8000000 (both chip-select bits 1, ready 1, length code 0, target 0).
- R2: The configuration register (offset 0x00) keeps only bit 28 (receive order) and bit 27 (transmit order). The control word (offset 0x08) keeps bit 31 (line 0 level), bit 30 (line 1 level), bits 29:28 (length code) and bit 24 (target). Bit 27 of the control word is the read-only ready flag, and all other bits read 0.
- R3: A write to the data register (offset 0x0C) while ready is 1 starts a transmit. Ready reads 0 from the next cycle until the last bit has been shifted, then reads 1 again.
- R4: Length code 0 moves one byte. On transmit that byte is write-data bits 31:24. On receive the byte is returned in bits 31:24 and bits 23:0 read 0.
- R5: Length codes 1, 2 and 3 each move four bytes (32 serial clock pulses).
- R6: In a four-byte transmit with configuration bit 27 set, write-data bits 31:24 go first on the wire. With it clear, bits 7:0 go first. Each byte is sent MSB first.
- R7: In a four-byte receive with configuration bit 28 set, the first wire byte lands in bits 31:24. With it clear, it lands in bits 7:0.
- R8: A read of the data register while ready is 1 returns the word captured by the previous receive and starts a new receive of the programmed length. The serial output stays low during a receive.
- R9: The serial clock idles low. Each high and each low phase lasts HALF_DIV system clocks, and a transfer of n bytes has exactly 8n rising edges.
- R10: A data-register write or read made while ready is 0 is ignored. It adds no clock pulses, changes no shifted data and does not alter the capture word.
- R11: Each chip-select pin equals its control-word bit, and is driven low as well while the engine is busy and the target field (0 = line 0, 1 = line 1) selects it.
- R12: The serial input is sampled on each rising edge of the serial clock. The first sampled bit becomes the MSB of the first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs0_n | output | 1 | Chip select 0, active low |
| spi_cs1_n | output | 1 | Chip select 1, active low |

## Verification
A wrong phase counter or bit counter shows up at once as a serial clock with the wrong pulse count or pulse width. That is visible within a single transfer, before ready rises again. A wrong byte-ordering latch or a wrong capture shift shows up only when the capture word is read back, which is one data read after the receive ends; the shifted wire pattern exposes a transmit ordering fault within the same transfer. A busy flag that ignores late accesses wrongly, or accepts them, shows up as extra clock pulses or a changed capture on the following receive. A chip-select fault is visible on the pins in the middle of any transfer.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    localparam int WORD_W = 32;
    localparam int NUM_CS = 2;

    localparam logic [7:0] OFS_CFG  = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_DATA = 8'h0C;

    localparam int CFG_RX_ORDER_BIT = 28;
    localparam int CFG_TX_ORDER_BIT = 27;
    localparam int CTRL_CS0_BIT     = 31;
    localparam int CTRL_CS1_BIT     = 30;
    localparam int CTRL_LEN_HI      = 29;
    localparam int CTRL_LEN_LO      = 28;
    localparam int CTRL_READY_BIT   = 27;
    localparam int CTRL_TARGET_BIT  = 24;

    typedef struct packed {
        logic rx_big;
        logic tx_big;
    } cfg_t;

    typedef struct packed {
        logic [NUM_CS-1:0] cs_level;
        logic [1:0]        len_code;
        logic              target;
    } ctrl_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2
    } eng_state_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic is_single(input logic [1:0] code);
        return (code == 2'd0);
    endfunction

    function automatic logic [5:0] bit_total(input logic [1:0] code);
        return is_single(code) ? 6'd8 : 6'd32;
    endfunction

    function automatic logic [WORD_W-1:0] tx_arrange(input logic [WORD_W-1:0] w,
                                                     input logic single,
                                                     input logic big);
        if (single || big) return w;
        return swap_bytes(w);
    endfunction

    function automatic logic [WORD_W-1:0] rx_arrange(input logic [WORD_W-1:0] r,
                                                     input logic single,
                                                     input logic big);
        if (single) return {r[7:0], 24'h0};
        if (big) return r;
        return swap_bytes(r);
    endfunction

endpackage

// File: rtl/sfm_regs.sv
module sfm_regs
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              eng_busy,
    input  logic [WORD_W-1:0] cap_word,
    output cfg_t              cfg,
    output ctrl_t             ctrl,
    output logic              start,
    output logic              start_rx,
    output logic [WORD_W-1:0] start_word,
    output logic [WORD_W-1:0] bus_rdata
);

    logic hit_cfg, hit_ctrl, hit_data;

    assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));

    // A data access launches only when the engine is free; a write wins over a read.
    assign start      = hit_data && (bus_wr || bus_rd) && !eng_busy;
    assign start_rx   = !bus_wr;
    assign start_word = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            ctrl <= '{cs_level: '1, len_code: 2'd0, target: 1'b0};
        end else if (bus_wr) begin
            if (hit_cfg) begin
                cfg.rx_big <= bus_wdata[CFG_RX_ORDER_BIT];
                cfg.tx_big <= bus_wdata[CFG_TX_ORDER_BIT];
            end
            if (hit_ctrl) begin
                ctrl.cs_level[0] <= bus_wdata[CTRL_CS0_BIT];
                ctrl.cs_level[1] <= bus_wdata[CTRL_CS1_BIT];
                ctrl.len_code    <= bus_wdata[CTRL_LEN_HI:CTRL_LEN_LO];
                ctrl.target      <= bus_wdata[CTRL_TARGET_BIT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_cfg) begin
            bus_rdata[CFG_RX_ORDER_BIT] = cfg.rx_big;
            bus_rdata[CFG_TX_ORDER_BIT] = cfg.tx_big;
        end else if (hit_ctrl) begin
            bus_rdata[CTRL_CS0_BIT]              = ctrl.cs_level[0];
            bus_rdata[CTRL_CS1_BIT]              = ctrl.cs_level[1];
            bus_rdata[CTRL_LEN_HI:CTRL_LEN_LO]   = ctrl.len_code;
            bus_rdata[CTRL_READY_BIT]            = !eng_busy;
            bus_rdata[CTRL_TARGET_BIT]           = ctrl.target;
        end else if (hit_data) begin
            bus_rdata = cap_word;
        end
    end

endmodule

// File: rtl/sfm_shift_engine.sv
module sfm_shift_engine
    import spi_flash_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_rx,
    input  logic [WORD_W-1:0] start_word,
    input  logic [1:0]        len_code,
    input  cfg_t              cfg,
    input  logic              miso,
    output logic              busy,
    output logic              rx_mode,
    output logic              sck,
    output logic              mosi,
    output logic [WORD_W-1:0] cap_word
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    eng_state_t        state;
    logic [DIV_W-1:0]  div_cnt;
    logic [5:0]        bits_left;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic              single_q;
    logic              rx_big_q;
    logic              sck_q;
    logic              phase_end;

    assign phase_end = (div_cnt == DIV_LAST);
    assign busy      = (state != ENG_IDLE);
    assign sck       = sck_q;
    assign mosi      = busy && !rx_mode && tx_sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            div_cnt   <= '0;
            bits_left <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            single_q  <= 1'b0;
            rx_big_q  <= 1'b0;
            rx_mode   <= 1'b0;
            sck_q     <= 1'b0;
            cap_word  <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state     <= ENG_LOW;
                        div_cnt   <= '0;
                        bits_left <= bit_total(len_code);
                        tx_sh     <= tx_arrange(start_word, is_single(len_code), cfg.tx_big);
                        rx_sh     <= '0;
                        single_q  <= is_single(len_code);
                        rx_big_q  <= cfg.rx_big;
                        rx_mode   <= start_rx;
                    end
                end
                ENG_LOW: begin
                    if (phase_end) begin
                        div_cnt <= '0;
                        state   <= ENG_HIGH;
                        sck_q   <= 1'b1;
                        rx_sh   <= {rx_sh[WORD_W-2:0], miso};
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ENG_HIGH: begin
                    if (phase_end) begin
                        div_cnt   <= '0;
                        sck_q     <= 1'b0;
                        tx_sh     <= {tx_sh[WORD_W-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == 6'd1) begin
                            state <= ENG_IDLE;
                            if (rx_mode) begin
                                cap_word <= rx_arrange(rx_sh, single_q, rx_big_q);
                            end
                        end else begin
                            state <= ENG_LOW;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sfm_cs_drive.sv
module sfm_cs_drive
    import spi_flash_pkg::*;
(
    input  logic [NUM_CS-1:0] cs_level,
    input  logic              target,
    input  logic              busy,
    output logic [NUM_CS-1:0] cs_n
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = cs_level[i] && !(busy && (target == 1'(i)));
    end

endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs0_n,
    output logic              spi_cs1_n
);

    cfg_t              cfg;
    ctrl_t             ctrl;
    logic              start, start_rx;
    logic [WORD_W-1:0] start_word;
    logic [WORD_W-1:0] cap_word;
    logic              eng_busy;
    logic              eng_rx;
    logic [NUM_CS-1:0] cs_n;

    sfm_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .eng_busy   (eng_busy),
        .cap_word   (cap_word),
        .cfg        (cfg),
        .ctrl       (ctrl),
        .start      (start),
        .start_rx   (start_rx),
        .start_word (start_word),
        .bus_rdata  (bus_rdata)
    );

    sfm_shift_engine #(.HALF_DIV(HALF_DIV)) i_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_rx   (start_rx),
        .start_word (start_word),
        .len_code   (ctrl.len_code),
        .cfg        (cfg),
        .miso       (spi_miso),
        .busy       (eng_busy),
        .rx_mode    (eng_rx),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .cap_word   (cap_word)
    );

    sfm_cs_drive i_cs (
        .cs_level (ctrl.cs_level),
        .target   (ctrl.target),
        .busy     (eng_busy),
        .cs_n     (cs_n)
    );

    assign spi_cs0_n = cs_n[0];
    assign spi_cs1_n = cs_n[1];

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              eng_busy,
    input logic              eng_rx,
    input logic              spi_sck,
    input logic              spi_mosi,
    input logic              spi_cs0_n,
    input logic              spi_cs1_n,
    input logic [1:0]        cs_level,
    input logic              target,
    input logic [1:0]        cfg_bits
);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> !spi_sck); // R9

    AST_SCK_RISE_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sck) |-> eng_busy); // R9

    AST_START_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_busy) |-> ($past(bus_addr) == ADDR_W'(12)) && $past(bus_wr || bus_rd)); // R3

    AST_RX_MOSI_LOW: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && eng_rx) |-> !spi_mosi); // R8

    AST_CS0_ENGINE: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !target) |-> !spi_cs0_n); // R11

    AST_CS1_ENGINE: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && target) |-> !spi_cs1_n); // R11

    AST_CS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> (spi_cs0_n == cs_level[0]) && (spi_cs1_n == cs_level[1])); // R11

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(cfg_bits)); // R2

endmodule

bind spi_flash_master sfm_checker #(.ADDR_W(ADDR_W)) i_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .eng_busy  (eng_busy),
    .eng_rx    (eng_rx),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_cs0_n (spi_cs0_n),
    .spi_cs1_n (spi_cs1_n),
    .cs_level  (ctrl.cs_level),
    .target    (ctrl.target),
    .cfg_bits  ({cfg.rx_big, cfg.tx_big})
);

// File: tb/test_spi_flash_master.sv
module test_spi_flash_master;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso, spi_cs0_n, spi_cs1_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    spi_flash_master #(.ADDR_W(4), .HALF_DIV(HALF)) i_spi_flash_master (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs0_n(spi_cs0_n),
        .spi_cs1_n(spi_cs1_n)
    );

    // Slave-side observers
    int          rise_cnt = 0;
    int          fall_cnt = 0;
    int          hi_cyc   = 0;
    int          fall_base = 0;
    logic [63:0] mosi_hist = '0;
    logic [31:0] miso_word = '0;
    logic [31:0] prev_cap  = '0;

    always @(posedge spi_sck) begin
        rise_cnt++;
        mosi_hist = {mosi_hist[62:0], spi_mosi};
    end
    always @(negedge spi_sck) fall_cnt++;
    always @(negedge clk) if (spi_sck) hi_cyc++;

    always_comb begin
        int k;
        k = fall_cnt - fall_base;
        spi_miso = (k >= 0 && k < 32) ? miso_word[31-k] : 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        do rd_reg(4'h8, v); while (!v[27]);
    endtask

    // Expected wire pattern of a transmit, first bit in the MSB of the used bits
    function automatic logic [31:0] exp_wire(input logic [31:0] w, input int nb, input bit big);
        logic [31:0] s = '0;
        for (int k = 0; k < nb; k++) begin
            logic [7:0] b;
            if (nb == 1)  b = w[31:24];
            else if (big) b = w[31-8*k -: 8];
            else          b = w[8*k +: 8];
            s = {s[23:0], b};
        end
        return s;
    endfunction

    // Expected capture word for a slave sending the top nb bytes of m, MSB first
    function automatic logic [31:0] exp_cap(input logic [31:0] m, input int nb, input bit big);
        logic [31:0] r = '0;
        for (int k = 0; k < nb; k++) begin
            logic [7:0] b = m[31-8*k -: 8];
            if (nb == 1)  r[31:24] = b;
            else if (big) r[31-8*k -: 8] = b;
            else          r[8*k +: 8] = b;
        end
        return r;
    endfunction

    task automatic run_xfer(input bit rx, input logic [31:0] word, input logic [1:0] len,
                            input bit sel, input bit rbig, input bit tbig);
        int nb, rb, hb;
        logic [31:0] v, mask, e;
        nb = (len == 2'd0) ? 1 : 4;
        mask = (nb == 1) ? 32'h0000_00FF : 32'hFFFF_FFFF;
        wr_reg(4'h0, {3'b0, rbig, tbig, 27'b0});
        wr_reg(4'h8, {2'b11, len, 3'b0, sel, 24'b0});
        rb = rise_cnt; hb = hi_cyc; fall_base = fall_cnt;
        miso_word = rx ? word : 32'h0;
        if (rx) begin
            rd_reg(4'hC, v);
            chk("R8 launching read returns previous capture", v, prev_cap);
        end else begin
            wr_reg(4'hC, word);
        end
        rd_reg(4'h8, v);
        chk("R3 ready low while shifting", {31'b0, v[27]}, 32'd0);
        // R10: late accesses while busy must be ignored
        wr_reg(4'hC, ~word);
        rd_reg(4'hC, v);
        @(negedge clk);
        chk("R11 target line low during transfer", {30'b0, spi_cs1_n, spi_cs0_n},
            sel ? 32'd1 : 32'd2);
        wait_ready();
        chk("R5/R10 rising edge count", rise_cnt - rb, 8 * nb);
        chk("R9 high phase cycles", hi_cyc - hb, 8 * nb * HALF);
        chk("R11 lines back to levels", {30'b0, spi_cs1_n, spi_cs0_n}, 32'd3);
        if (!rx) begin
            chk("R4/R6 transmit wire bits", mosi_hist[31:0] & mask, exp_wire(word, nb, tbig));
        end else begin
            chk("R8 MOSI low on receive", mosi_hist[31:0] & mask, 32'd0);
            e = exp_cap(word, nb, rbig);
            fall_base = fall_cnt;
            rd_reg(4'hC, v);
            chk("R7/R12/R4 captured word", v, e);
            wait_ready();
            prev_cap = e;
        end
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs pins high", {30'b0, spi_cs1_n, spi_cs0_n}, 32'd3);
        chk("R1 sck low", {31'b0, spi_sck}, 32'd0);
        rd_reg(4'h0, v); chk("R1 config reset", v, 32'h0);
        rd_reg(4'h8, v); chk("R1 control reset", v, 32'hC800_0000);

        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0, v); chk("R2 config kept bits", v, 32'h1800_0000);
        wr_reg(4'h8, 32'hFFFF_FFFF);
        rd_reg(4'h8, v); chk("R2 control kept bits", v, 32'hF900_0000);
        wr_reg(4'h8, 32'h4000_0000);
        @(negedge clk);
        chk("R11 manual line 0", {30'b0, spi_cs1_n, spi_cs0_n}, 32'd2);
        wr_reg(4'h8, 32'h8000_0000);
        @(negedge clk);
        chk("R11 manual line 1", {30'b0, spi_cs1_n, spi_cs0_n}, 32'd1);

        // Directed corner cases
        run_xfer(1'b0, 32'hA5C3_1234, 2'd0, 1'b0, 1'b0, 1'b0);
        run_xfer(1'b0, 32'h1122_3344, 2'd3, 1'b0, 1'b0, 1'b1);
        run_xfer(1'b0, 32'h1122_3344, 2'd3, 1'b1, 1'b0, 1'b0);
        run_xfer(1'b0, 32'hDEAD_BEEF, 2'd1, 1'b0, 1'b0, 1'b1);
        run_xfer(1'b1, 32'h9ABC_DEF0, 2'd0, 1'b0, 1'b0, 1'b0);
        run_xfer(1'b1, 32'h0102_0304, 2'd3, 1'b1, 1'b1, 1'b0);
        run_xfer(1'b1, 32'h0102_0304, 2'd2, 1'b0, 1'b0, 1'b0);
        run_xfer(1'b0, 32'h8000_0001, 2'd3, 1'b1, 1'b1, 1'b1);

        // Constrained random transfers
        for (int i = 0; i < 24; i++) begin
            run_xfer(1'($urandom), $urandom, 2'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R3 watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule